// File: doc/BRIEF.md
# Narrow Edge Filter with Range Clamping

This block smooths a block boundary in a decoded picture by adjusting the two samples on each side of the edge: p1 and p0 on one side, q0 and q1 on the other. A single correction value is derived from the step across the edge. It is split into two asymmetrically rounded taps for the inner pair, and into a halved tap for the outer pair when the edge is not busy. Every intermediate term saturates to a signed range that depends on the sample depth, and every output sample is clamped to the legal pixel range.

The caller supplies the four samples, a busy-edge flag (high variance across the edge), an enable mask that says whether this position is filtered at all, and a depth select. Deciding the mask and running the wider filters happen elsewhere. The datapath is combinational and is followed by an output register that a parameter can remove.

Top module: `nef_edge4`

## Requirements
- R1: The depth select `depth12_i` chooses 12-bit samples when 1 and 10-bit samples when 0. In 10-bit mode the two upper bits of every sample input are zero, and outputs then stay below 1024.
- R2: The signed saturation range is -512..511 for 10-bit samples and -2048..2047 for 12-bit samples. It applies to the outer term, to the combined value and to the rounded taps.
- R3: When `mask_i` is 0, the correction is zero and all four outputs equal their inputs.
- R4: With mask set, the correction is sat(3*(q0-p0) + t). Here t = sat(p1-q1) when `hev_i` is 1, and t = 0 when `hev_i` is 0.
- R5: The inner taps are a = min(c+4, smax) >>> 3 and b = min(c+3, smax) >>> 3, using arithmetic shifts, so a - b is always 0 or 1.
- R6: q0 out = q0 - a and p0 out = p0 + b, each clamped to 0..2^depth-1.
- R7: When `hev_i` is 0, p1 out = p1 + ((a+1)>>>1) and q1 out = q1 - ((a+1)>>>1), each clamped to 0..2^depth-1.
- R8: When `hev_i` is 1, p1 and q1 pass to the outputs unchanged.
- R9: Every output lies within 0..2^depth-1 when the inputs obey R1.
- R10: With the output register enabled (default), a result appears one clock after its inputs. An active-low reset forces all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| p1_i | input | 12 | Outer sample before the edge |
| p0_i | input | 12 | Inner sample before the edge |
| q0_i | input | 12 | Inner sample after the edge |
| q1_i | input | 12 | Outer sample after the edge |
| hev_i | input | 1 | Busy-edge flag |
| mask_i | input | 1 | Filter enable for this position |
| depth12_i | input | 1 | 1 = 12-bit, 0 = 10-bit samples |
| p1_o | output | 12 | Filtered p1 |
| p0_o | output | 12 | Filtered p0 |
| q0_o | output | 12 | Filtered q0 |
| q1_o | output | 12 | Filtered q1 |

## Verification
The assertions check four things on every cycle: the pass-through of the outer pair under a busy edge, the identity when the mask is clear, the 0-or-1 gap between the two inner taps, and the output range. The exact arithmetic cannot be seen by those properties. That covers the signed saturation points at each depth, the tripling of the inner step, and the halving of the outer tap. Only the bench's comparison against an independent integer model shows it, over random and saturating inputs at both depths. The bench also shows the one-cycle latency and the reset value.

// File: rtl/nef_pkg.sv
package nef_pkg;
    localparam int NEF_SW = 12;
    localparam int NEF_DW = NEF_SW + 4;

    typedef logic [NEF_SW-1:0]        smp_t;
    typedef logic signed [NEF_DW-1:0] acc_t;

    typedef struct packed {
        smp_t p1;
        smp_t p0;
        smp_t q0;
        smp_t q1;
    } quad_t;

    // zero-extend a sample into the signed working width
    function automatic acc_t widen(input smp_t s);
        return $signed({{(NEF_DW-NEF_SW){1'b0}}, s});
    endfunction

    function automatic acc_t sclip(input acc_t v, input acc_t lo, input acc_t hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic smp_t uclip(input acc_t v, input acc_t hi);
        if (v < acc_t'(0)) return '0;
        if (v > hi) return hi[NEF_SW-1:0];
        return v[NEF_SW-1:0];
    endfunction
endpackage

// File: rtl/nef_delta.sv
// Correction value and the two rounded inner taps (R2, R4, R5).
module nef_delta
    import nef_pkg::*;
(
    input  quad_t px,
    input  logic  hev,
    input  logic  mask,
    input  logic  d12,
    output acc_t  f1,
    output acc_t  f2
);
    localparam acc_t MAX_LO = acc_t'(2**(NEF_SW-3) - 1);
    localparam acc_t MAX_HI = acc_t'(2**(NEF_SW-1) - 1);
    localparam acc_t K1 = acc_t'(1);
    localparam acc_t K3 = acc_t'(3);
    localparam acc_t K4 = acc_t'(4);

    typedef struct packed {
        acc_t smax;
        acc_t smin;
        acc_t outer;
        acc_t base;
        acc_t corr;
        acc_t r4;
        acc_t r3;
    } delta_t;

    delta_t dl_d;

    always_comb begin
        dl_d.smax  = d12 ? MAX_HI : MAX_LO;
        dl_d.smin  = -dl_d.smax - K1;
        dl_d.outer = hev ? sclip(widen(px.p1) - widen(px.q1), dl_d.smin, dl_d.smax) : '0;
        dl_d.base  = K3 * (widen(px.q0) - widen(px.p0)) + dl_d.outer;
        dl_d.corr  = mask ? sclip(dl_d.base, dl_d.smin, dl_d.smax) : '0;
        dl_d.r4    = (dl_d.corr + K4 > dl_d.smax) ? dl_d.smax : dl_d.corr + K4;
        dl_d.r3    = (dl_d.corr + K3 > dl_d.smax) ? dl_d.smax : dl_d.corr + K3;
    end

    assign f1 = dl_d.r4 >>> 3;
    assign f2 = dl_d.r3 >>> 3;
endmodule

// File: rtl/nef_apply.sv
// Applies the taps to the four samples with unsigned clamping (R6, R7, R8).
module nef_apply
    import nef_pkg::*;
(
    input  quad_t px,
    input  acc_t  f1,
    input  acc_t  f2,
    input  logic  hev,
    input  logic  d12,
    output quad_t py
);
    localparam acc_t UMAX_LO = acc_t'(2**(NEF_SW-2) - 1);
    localparam acc_t UMAX_HI = acc_t'(2**NEF_SW - 1);
    localparam acc_t K1 = acc_t'(1);

    acc_t umax;
    acc_t half;

    always_comb begin
        umax  = d12 ? UMAX_HI : UMAX_LO;
        half  = (f1 + K1) >>> 1;
        py.q0 = uclip(widen(px.q0) - f1, umax);
        py.p0 = uclip(widen(px.p0) + f2, umax);
        if (hev) begin
            py.p1 = px.p1;
            py.q1 = px.q1;
        end else begin
            py.p1 = uclip(widen(px.p1) + half, umax);
            py.q1 = uclip(widen(px.q1) - half, umax);
        end
    end
endmodule

// File: rtl/nef_edge4.sv
module nef_edge4
    import nef_pkg::*;
#(
    parameter bit PIPE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEF_SW-1:0] p1_i,
    input  logic [NEF_SW-1:0] p0_i,
    input  logic [NEF_SW-1:0] q0_i,
    input  logic [NEF_SW-1:0] q1_i,
    input  logic              hev_i,
    input  logic              mask_i,
    input  logic              depth12_i,
    output logic [NEF_SW-1:0] p1_o,
    output logic [NEF_SW-1:0] p0_o,
    output logic [NEF_SW-1:0] q0_o,
    output logic [NEF_SW-1:0] q1_o
);
    localparam smp_t UMAX_LO = smp_t'(2**(NEF_SW-2) - 1);

    quad_t in_w;
    quad_t out_d;
    quad_t out_q;
    acc_t  f1_w;
    acc_t  f2_w;
    logic  in_ok;

    assign in_w = {p1_i, p0_i, q0_i, q1_i};

    nef_delta u_delta (
        .px   (in_w),
        .hev  (hev_i),
        .mask (mask_i),
        .d12  (depth12_i),
        .f1   (f1_w),
        .f2   (f2_w)
    );

    nef_apply u_apply (
        .px  (in_w),
        .f1  (f1_w),
        .f2  (f2_w),
        .hev (hev_i),
        .d12 (depth12_i),
        .py  (out_d)
    );

    generate
        if (PIPE_EN) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
        end else begin : g_wire
            assign out_q = out_d;
        end
    endgenerate

    assign p1_o = out_q.p1;
    assign p0_o = out_q.p0;
    assign q0_o = out_q.q0;
    assign q1_o = out_q.q1;

    // inputs legal for the selected depth (R1)
    assign in_ok = depth12_i ||
                   (p1_i[NEF_SW-1 -: 2] == 2'b00 && p0_i[NEF_SW-1 -: 2] == 2'b00 &&
                    q0_i[NEF_SW-1 -: 2] == 2'b00 && q1_i[NEF_SW-1 -: 2] == 2'b00);

    assert_hev_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hev_i |-> (out_d.p1 == p1_i && out_d.q1 == q1_i));

    assert_mask_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_i && in_ok) |-> (out_d == in_w));

    assert_tap_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (f1_w == f2_w) || (f1_w == f2_w + acc_t'(1)));

    assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ok && !depth12_i) |-> (out_d.p1 <= UMAX_LO && out_d.p0 <= UMAX_LO &&
                                   out_d.q0 <= UMAX_LO && out_d.q1 <= UMAX_LO));
endmodule

// File: tb/nef_edge4_tb_top.sv
module nef_edge4_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] p1_i = '0, p0_i = '0, q0_i = '0, q1_i = '0;
    logic        hev_i = 1'b0, mask_i = 1'b0, depth12_i = 1'b0;
    logic [11:0] p1_o, p0_o, q0_o, q1_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nef_edge4 dut_i (
        .clk(clk), .rst_n(rst_n),
        .p1_i(p1_i), .p0_i(p0_i), .q0_i(q0_i), .q1_i(q1_i),
        .hev_i(hev_i), .mask_i(mask_i), .depth12_i(depth12_i),
        .p1_o(p1_o), .p0_o(p0_o), .q0_o(q0_o), .q1_o(q1_o)
    );

    function automatic int clip(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // independent integer model of R2..R8
    task automatic model(input int p1, input int p0, input int q0, input int q1,
                         input bit h, input bit m, input bit z,
                         output int e1, output int e0, output int eq0, output int eq1);
        int smax, smin, umax, c, a, b, t;
        smax = z ? 2047 : 511;
        smin = -smax - 1;
        umax = z ? 4095 : 1023;
        c = h ? clip(p1 - q1, smin, smax) : 0;
        c = clip(3 * (q0 - p0) + c, smin, smax);
        if (!m) c = 0;
        a = ((c + 4 > smax) ? smax : c + 4) >>> 3;
        b = ((c + 3 > smax) ? smax : c + 3) >>> 3;
        eq0 = clip(q0 - a, 0, umax);
        e0  = clip(p0 + b, 0, umax);
        if (h) begin
            e1 = p1; eq1 = q1;
        end else begin
            t = (a + 1) >>> 1;
            e1  = clip(p1 + t, 0, umax);
            eq1 = clip(q1 - t, 0, umax);
        end
    endtask

    task automatic compare(input string tag, input int e1, input int e0, input int eq0, input int eq1);
        total++;
        if (int'(p1_o) != e1 || int'(p0_o) != e0 || int'(q0_o) != eq0 || int'(q1_o) != eq1) begin
            bad++;
            $display("FAIL %s: got p1=%0d p0=%0d q0=%0d q1=%0d exp p1=%0d p0=%0d q0=%0d q1=%0d",
                     tag, p1_o, p0_o, q0_o, q1_o, e1, e0, eq0, eq1);
        end
    endtask

    // drive at a falling edge, result registered at the next rising edge, sample at the falling edge after
    task automatic run(input int p1, input int p0, input int q0, input int q1,
                       input bit h, input bit m, input bit z, input string tag);
        int e1, e0, eq0, eq1;
        p1_i = 12'(p1); p0_i = 12'(p0); q0_i = 12'(q0); q1_i = 12'(q1);
        hev_i = h; mask_i = m; depth12_i = z;
        model(p1, p0, q0, q1, h, m, z, e1, e0, eq0, eq1);
        @(negedge clk);
        compare(tag, e1, e0, eq0, eq1);
    endtask

    function automatic int pick(input bit z);
        int umax, sel;
        umax = z ? 4095 : 1023;
        sel = $urandom_range(0, 7);
        if (sel == 0) return $urandom_range(0, 3);
        if (sel == 1) return umax - $urandom_range(0, 3);
        return $urandom_range(0, umax);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e1, e0, eq0, eq1;
        void'($urandom(32'h00c0ffee));
        @(negedge clk);
        @(negedge clk);
        // R10: reset clears outputs
        compare("R10 reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: busy edge, outer term included; positive step saturates at 10 bit (R2)
        run(900, 0, 1023, 100, 1'b1, 1'b1, 1'b0, "R4 R2 hev sat10");
        run(0, 0, 4095, 4095, 1'b1, 1'b1, 1'b1, "R4 R2 hev sat12");
        // R2: negative saturation at both depths
        run(10, 1023, 0, 1000, 1'b1, 1'b1, 1'b0, "R2 neg10");
        run(10, 4095, 0, 4000, 1'b1, 1'b1, 1'b1, "R2 neg12");
        // R5: small corrections exercise +4/+3 rounding
        run(500, 500, 501, 500, 1'b0, 1'b1, 1'b0, "R5 round c=3");
        run(500, 501, 500, 500, 1'b0, 1'b1, 1'b0, "R5 round c=-3");
        run(500, 500, 502, 500, 1'b1, 1'b1, 1'b1, "R5 round c=6");
        // R6 R9: clamping of inner samples at range edges
        run(0, 1023, 1023, 1023, 1'b0, 1'b1, 1'b0, "R6 R9 clamp hi");
        run(1020, 2, 0, 3, 1'b0, 1'b1, 1'b0, "R6 R9 clamp lo");
        // R7: outer adjustment when the edge is quiet
        run(200, 300, 340, 400, 1'b0, 1'b1, 1'b1, "R7 outer adj");
        // R8: outer samples untouched when busy
        run(4095, 1000, 3000, 0, 1'b1, 1'b1, 1'b1, "R8 hold");
        // R3: mask clear leaves everything alone
        run(1023, 0, 1023, 0, 1'b0, 1'b0, 1'b0, "R3 idle");
        // R1: same samples give different results per depth select
        run(100, 200, 900, 300, 1'b0, 1'b1, 1'b0, "R1 depth10");
        run(100, 200, 900, 300, 1'b0, 1'b1, 1'b1, "R1 depth12");

        // R10: output holds the previous result until the next rising edge
        model(100, 200, 900, 300, 1'b0, 1'b1, 1'b1, e1, e0, eq0, eq1);
        p1_i = 12'd5; p0_i = 12'd6; q0_i = 12'd700; q1_i = 12'd8;
        #1;
        compare("R10 latency", e1, e0, eq0, eq1);
        @(negedge clk);

        for (int i = 0; i < 1200; i++) begin
            bit z, h, m;
            string tag;
            z = i[0];
            h = ($urandom_range(0, 1) == 1);
            m = ($urandom_range(0, 5) != 0);
            tag = !m ? "R3 rand" : (h ? "R8 R4 rand" : "R7 R6 rand");
            run(pick(z), pick(z), pick(z), pick(z), h, m, z, tag);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule